// File: doc/BRIEF.md
# Pointer Alias Check Unit

This block tags object pointers with a short, nearly unique identifier and uses that tag to decide whether two memory references must be ordered. A pointer word is 64 bits. The upper 16 bits hold the tag and the lower 48 bits hold the object address. When an object is allocated, its pointer gets a fresh tag built from a free-running pseudo-random sequence. Any pointer derived later from that object keeps the parent's tag, whether the derived pointer is a forwarding copy to a new location or an interior pointer into the object.

The unit has three independent request ports, each with a valid/ready handshake on the request side and on the response side:

- The allocate port takes an address and returns a tagged pointer.
- The derive port takes a tagged parent pointer and either a replacement address or a byte offset, and returns the derived pointer.
- The compare port takes two tagged pointers. It returns a barrier flag and a two-bit verdict.

The verdict is:

- Identical pointers need a barrier.
- Different pointers that carry the same tag also need a barrier, since they may alias inside one object. This should be uncommon.
- Pointers that differ in both address and tag need no barrier.

Each port holds one result. The result is registered in the cycle after the request is accepted and stays there until the consumer takes it.

Top module: `alias_check_unit`

## Requirements
- R1: After reset every response valid is low, every request ready is high, and the tag generator restarts from the seed 0xACE1. A second reset in mid-run also restarts the sequence from the seed.
- R2: An accepted allocation returns `{tag, addr}`, with the tag in bits 63:48 and the address in bits 47:0. The tag is the current generator state XOR the address fold. The fold is addr[15:0] ^ addr[31:16] ^ addr[47:32].
- R3: The generator advances exactly once for each accepted allocation, and at no other time. Each step is a right shift that XORs in the mask 0xB400 when the bit shifted out is 1. Stalled allocation requests do not advance it.
- R4: A derive request with the forward bit set returns the parent's tag together with the supplied address.
- R5: A derive request with the forward bit clear returns the parent's tag together with the sum of the parent address and the supplied offset, taken modulo 2^48.
- R6: Comparing two identical pointers gives verdict 2'b01 and barrier high.
- R7: Comparing two pointers whose addresses differ but whose tags match gives verdict 2'b10 and barrier high.
- R8: Comparing two pointers whose tags differ gives verdict 2'b00 and barrier low. This holds even when the addresses are equal.
- R9: The response of each port becomes valid in the cycle after its request is accepted. While the response is valid and its ready is low, the response stays unchanged and the request ready is low. When the response is taken with no new request, its valid drops.
- R10: The three ports work independently, so requests accepted in the same cycle each produce their correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocation request valid |
| alloc_ready | output | 1 | Allocation request ready |
| alloc_addr | input | 48 | Address of the new object |
| alloc_rsp_valid | output | 1 | Tagged pointer valid |
| alloc_rsp_ready | input | 1 | Consumer takes the tagged pointer |
| alloc_rsp_ptr | output | 64 | Tagged pointer {tag, addr} |
| drv_valid | input | 1 | Derive request valid |
| drv_ready | output | 1 | Derive request ready |
| drv_fwd | input | 1 | 1: replace the address; 0: add an offset |
| drv_parent | input | 64 | Parent tagged pointer |
| drv_addr | input | 48 | Replacement address or offset |
| drv_rsp_valid | output | 1 | Derived pointer valid |
| drv_rsp_ready | input | 1 | Consumer takes the derived pointer |
| drv_rsp_ptr | output | 64 | Derived tagged pointer |
| cmp_valid | input | 1 | Compare request valid |
| cmp_ready | output | 1 | Compare request ready |
| cmp_ptr_a | input | 64 | First tagged pointer |
| cmp_ptr_b | input | 64 | Second tagged pointer |
| cmp_rsp_valid | output | 1 | Verdict valid |
| cmp_rsp_ready | input | 1 | Consumer takes the verdict |
| cmp_rsp_barrier | output | 1 | Barrier required |
| cmp_rsp_kind | output | 2 | Verdict: 00 distinct, 01 same pointer, 10 tag match |

## Verification
Every result of this block is due exactly one clock edge after its request is accepted. The bench drives each request on a falling edge and reads the response on the next falling edge, which is one rising edge later. The allocation checks advance an independent generator model once per accepted request, so a tag can only match if the design advanced for exactly the same requests. The stall scenarios hold the response ready low for several cycles. In each of those cycles the bench checks that the held result and the low request ready stay unchanged, and then that the next result is due one edge after ready returns.

// File: rtl/alias_pkg.sv
package alias_pkg;
    parameter int ADDR_W = 48;
    parameter int TAG_W  = 16;
    localparam int PTR_W = ADDR_W + TAG_W;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
    } tptr_t;

    typedef enum logic [1:0] {
        ALIAS_NONE = 2'b00,
        ALIAS_SAME = 2'b01,
        ALIAS_TAG  = 2'b10
    } alias_kind_e;

    // Bit i of the address lands on tag bit (i mod TAG_W).
    function automatic logic [TAG_W-1:0] fold_addr(input logic [ADDR_W-1:0] a);
        logic [TAG_W-1:0] f;
        f = '0;
        for (int i = 0; i < ADDR_W; i++) begin
            f[i % TAG_W] = f[i % TAG_W] ^ a[i];
        end
        return f;
    endfunction
endpackage

// File: rtl/alias_tag_gen.sv
module alias_tag_gen
    import alias_pkg::*;
#(
    parameter logic [TAG_W-1:0] SEED = 16'hACE1,
    parameter logic [TAG_W-1:0] TAPS = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [TAG_W-1:0] state
);
    typedef struct packed {
        logic [TAG_W-1:0] lfsr;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.lfsr = {1'b0, st_q.lfsr[TAG_W-1:1]} ^ (st_q.lfsr[0] ? TAPS : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lfsr: SEED};
        else        st_q <= st_d;
    end

    assign state = st_q.lfsr;

    assert_lfsr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(state));
    assert_lfsr_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> state != $past(state));
    assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/alias_alloc_stage.sv
module alias_alloc_stage
    import alias_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  lfsr,
    output logic              accept,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output tptr_t             rsp_ptr
);
    typedef struct packed {
        logic  valid;
        tptr_t ptr;
    } slot_t;

    slot_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        req_ready = !st_q.valid || rsp_ready;
        accept    = req_valid && req_ready;
        if (accept) begin
            st_d.valid    = 1'b1;
            st_d.ptr.tag  = lfsr ^ fold_addr(req_addr);
            st_d.ptr.addr = req_addr;
        end else if (rsp_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_ptr   = st_q.ptr;

    assert_alloc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ptr));
    assert_alloc_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid && rsp_ptr.addr == $past(req_addr));
    assert_alloc_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rsp_ptr.tag ^ fold_addr(rsp_ptr.addr)) == $past(lfsr));
endmodule

// File: rtl/alias_derive_stage.sv
module alias_derive_stage
    import alias_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_fwd,
    input  tptr_t             req_parent,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output tptr_t             rsp_ptr
);
    typedef struct packed {
        logic  valid;
        tptr_t ptr;
    } slot_t;

    slot_t st_d, st_q;
    logic  accept;

    always_comb begin
        st_d      = st_q;
        req_ready = !st_q.valid || rsp_ready;
        accept    = req_valid && req_ready;
        if (accept) begin
            st_d.valid   = 1'b1;
            st_d.ptr.tag = req_parent.tag;
            if (req_fwd) st_d.ptr.addr = req_addr;
            else         st_d.ptr.addr = req_parent.addr + req_addr;
        end else if (rsp_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_ptr   = st_q.ptr;

    assert_drv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ptr));
    assert_drv_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> rsp_valid && rsp_ptr.tag == $past(req_parent.tag));
    assert_drv_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_fwd |=> rsp_ptr.addr == $past(req_addr));
endmodule

// File: rtl/alias_cmp_stage.sv
module alias_cmp_stage
    import alias_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  tptr_t       req_a,
    input  tptr_t       req_b,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic        rsp_barrier,
    output alias_kind_e rsp_kind
);
    typedef struct packed {
        logic        valid;
        alias_kind_e kind;
    } slot_t;

    slot_t st_d, st_q;
    logic  accept;

    always_comb begin
        st_d      = st_q;
        req_ready = !st_q.valid || rsp_ready;
        accept    = req_valid && req_ready;
        if (accept) begin
            st_d.valid = 1'b1;
            if (req_a == req_b)              st_d.kind = ALIAS_SAME;
            else if (req_a.tag == req_b.tag) st_d.kind = ALIAS_TAG;
            else                             st_d.kind = ALIAS_NONE;
        end else if (rsp_ready) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{valid: 1'b0, kind: ALIAS_NONE};
        else        st_q <= st_d;
    end

    assign rsp_valid   = st_q.valid;
    assign rsp_kind    = st_q.kind;
    assign rsp_barrier = st_q.kind != ALIAS_NONE;

    assert_cmp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind));
    assert_cmp_same_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_a == req_b |=> rsp_barrier && rsp_kind == ALIAS_SAME);
    assert_cmp_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_a != req_b && req_a.tag == req_b.tag |=> rsp_barrier && rsp_kind == ALIAS_TAG);
    assert_cmp_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept && req_a.tag != req_b.tag |=> !rsp_barrier);
endmodule

// File: rtl/alias_check_unit.sv
module alias_check_unit
    import alias_pkg::*;
#(
    parameter logic [TAG_W-1:0] SEED = 16'hACE1,
    parameter logic [TAG_W-1:0] TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    output logic              alloc_ready,
    input  logic [ADDR_W-1:0] alloc_addr,
    output logic              alloc_rsp_valid,
    input  logic              alloc_rsp_ready,
    output logic [PTR_W-1:0]  alloc_rsp_ptr,
    input  logic              drv_valid,
    output logic              drv_ready,
    input  logic              drv_fwd,
    input  logic [PTR_W-1:0]  drv_parent,
    input  logic [ADDR_W-1:0] drv_addr,
    output logic              drv_rsp_valid,
    input  logic              drv_rsp_ready,
    output logic [PTR_W-1:0]  drv_rsp_ptr,
    input  logic              cmp_valid,
    output logic              cmp_ready,
    input  logic [PTR_W-1:0]  cmp_ptr_a,
    input  logic [PTR_W-1:0]  cmp_ptr_b,
    output logic              cmp_rsp_valid,
    input  logic              cmp_rsp_ready,
    output logic              cmp_rsp_barrier,
    output logic [1:0]        cmp_rsp_kind
);
    logic [TAG_W-1:0] lfsr_w;
    logic             alloc_take_w;
    tptr_t            alloc_ptr_w, drv_ptr_w;
    alias_kind_e      kind_w;

    alias_tag_gen #(.SEED(SEED), .TAPS(TAPS)) u_gen (
        .clk(clk), .rst_n(rst_n), .advance(alloc_take_w), .state(lfsr_w)
    );

    alias_alloc_stage u_alloc (
        .clk(clk), .rst_n(rst_n),
        .req_valid(alloc_valid), .req_ready(alloc_ready), .req_addr(alloc_addr),
        .lfsr(lfsr_w), .accept(alloc_take_w),
        .rsp_valid(alloc_rsp_valid), .rsp_ready(alloc_rsp_ready), .rsp_ptr(alloc_ptr_w)
    );

    alias_derive_stage u_drv (
        .clk(clk), .rst_n(rst_n),
        .req_valid(drv_valid), .req_ready(drv_ready), .req_fwd(drv_fwd),
        .req_parent(tptr_t'(drv_parent)), .req_addr(drv_addr),
        .rsp_valid(drv_rsp_valid), .rsp_ready(drv_rsp_ready), .rsp_ptr(drv_ptr_w)
    );

    alias_cmp_stage u_cmp (
        .clk(clk), .rst_n(rst_n),
        .req_valid(cmp_valid), .req_ready(cmp_ready),
        .req_a(tptr_t'(cmp_ptr_a)), .req_b(tptr_t'(cmp_ptr_b)),
        .rsp_valid(cmp_rsp_valid), .rsp_ready(cmp_rsp_ready),
        .rsp_barrier(cmp_rsp_barrier), .rsp_kind(kind_w)
    );

    assign alloc_rsp_ptr = alloc_ptr_w;
    assign drv_rsp_ptr   = drv_ptr_w;
    assign cmp_rsp_kind  = kind_w;

    assert_ports_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid && alloc_ready |=> alloc_rsp_valid);
    assert_drv_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drv_valid && drv_ready |=> drv_rsp_valid);
    assert_cmp_due_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid && cmp_ready |=> cmp_rsp_valid);
endmodule

// File: tb/tb_alias_check_unit.sv
module tb_alias_check_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, alloc_ready, alloc_rsp_valid, alloc_rsp_ready = 1'b1;
    logic [47:0] alloc_addr = '0;
    logic [63:0] alloc_rsp_ptr;
    logic        drv_valid = 1'b0, drv_ready, drv_fwd = 1'b0, drv_rsp_valid, drv_rsp_ready = 1'b1;
    logic [63:0] drv_parent = '0, drv_rsp_ptr;
    logic [47:0] drv_addr = '0;
    logic        cmp_valid = 1'b0, cmp_ready, cmp_rsp_valid, cmp_rsp_ready = 1'b1, cmp_rsp_barrier;
    logic [63:0] cmp_ptr_a = '0, cmp_ptr_b = '0;
    logic [1:0]  cmp_rsp_kind;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [15:0] m_lfsr = 16'hACE1;

    always #4 clk = ~clk;

    alias_check_unit dut (.*);

    function automatic logic [15:0] fold(input logic [47:0] a);
        return a[15:0] ^ a[31:16] ^ a[47:32];
    endfunction

    function automatic logic [15:0] step(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_alloc(input logic [47:0] a, input string req);
        logic [63:0] exp;
        @(negedge clk);
        alloc_valid = 1'b1; alloc_addr = a;
        exp = {m_lfsr ^ fold(a), a};
        @(negedge clk);
        alloc_valid = 1'b0;
        m_lfsr = step(m_lfsr);
        chk(alloc_rsp_valid == 1'b1, req, {63'd0, alloc_rsp_valid}, 64'd1);
        chk(alloc_rsp_ptr == exp, req, alloc_rsp_ptr, exp);
    endtask

    task automatic do_derive(input logic [63:0] par, input logic fwd, input logic [47:0] a,
                             input logic [63:0] exp, input string req);
        @(negedge clk);
        drv_valid = 1'b1; drv_parent = par; drv_fwd = fwd; drv_addr = a;
        @(negedge clk);
        drv_valid = 1'b0;
        chk(drv_rsp_valid == 1'b1, req, {63'd0, drv_rsp_valid}, 64'd1);
        chk(drv_rsp_ptr == exp, req, drv_rsp_ptr, exp);
    endtask

    task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input logic [1:0] k, input string req);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_ptr_a = a; cmp_ptr_b = b;
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(cmp_rsp_valid == 1'b1, req, {63'd0, cmp_rsp_valid}, 64'd1);
        chk(cmp_rsp_kind == k, req, {62'd0, cmp_rsp_kind}, {62'd0, k});
        chk(cmp_rsp_barrier == (k != 2'b00), req, {63'd0, cmp_rsp_barrier}, {63'd0, k != 2'b00});
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!alloc_rsp_valid && !drv_rsp_valid && !cmp_rsp_valid, "R1 valids low",
            {61'd0, alloc_rsp_valid, drv_rsp_valid, cmp_rsp_valid}, 64'd0);
        chk(alloc_ready && drv_ready && cmp_ready, "R1 readies high",
            {61'd0, alloc_ready, drv_ready, cmp_ready}, 64'd7);
    endtask

    task automatic test_alloc_sequence();
        do_alloc(48'h0000_0000_1000, "R2 R1 first alloc from seed");
        do_alloc(48'h1234_5678_9ABC, "R2 R3 second alloc");
        do_alloc(48'hFFFF_FFFF_FFFF, "R2 R3 all-ones addr");
        do_alloc(48'h0000_0000_0000, "R2 R3 zero addr");
        do_alloc(48'h8000_0001_0002, "R2 R3 fifth alloc");
    endtask

    task automatic test_alloc_stall();
        logic [63:0] exp_a, exp_b;
        logic [47:0] a = 48'hABCD_0000_1111, b = 48'h0F0F_F0F0_5555;
        @(negedge clk);
        alloc_rsp_ready = 1'b0; alloc_valid = 1'b1; alloc_addr = a;
        exp_a = {m_lfsr ^ fold(a), a};
        @(negedge clk);
        m_lfsr = step(m_lfsr);
        alloc_addr = b;
        chk(alloc_rsp_ptr == exp_a, "R9 stall first result", alloc_rsp_ptr, exp_a);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(alloc_rsp_valid && alloc_rsp_ptr == exp_a, "R9 held while stalled", alloc_rsp_ptr, exp_a);
            chk(alloc_ready == 1'b0, "R9 ready low while held", {63'd0, alloc_ready}, 64'd0);
        end
        exp_b = {m_lfsr ^ fold(b), b};
        alloc_rsp_ready = 1'b1;
        @(negedge clk);
        alloc_valid = 1'b0;
        m_lfsr = step(m_lfsr);
        chk(alloc_rsp_ptr == exp_b, "R3 stalled cycles did not advance", alloc_rsp_ptr, exp_b);
        @(negedge clk);
        chk(alloc_rsp_valid == 1'b0, "R9 valid drops when taken", {63'd0, alloc_rsp_valid}, 64'd0);
    endtask

    task automatic test_derive();
        do_derive(64'h5A5A_0000_0000_4000, 1'b1, 48'h7777_0000_0010, 64'h5A5A_7777_0000_0010, "R4 forward");
        do_derive(64'h1357_0000_0000_4000, 1'b0, 48'h0000_0000_0028, 64'h1357_0000_0000_4028, "R5 interior offset");
        do_derive(64'hBEEF_FFFF_FFFF_FFF0, 1'b0, 48'h0000_0000_0020, 64'hBEEF_0000_0000_0010, "R5 offset wraps");
    endtask

    task automatic test_compare();
        do_cmp(64'h1111_0000_0000_2000, 64'h1111_0000_0000_2000, 2'b01, "R6 identical");
        do_cmp(64'h2222_0000_0000_2000, 64'h2222_0000_0000_2008, 2'b10, "R7 tag match");
        do_cmp(64'h3333_0000_0000_2000, 64'h4444_0000_0000_2000, 2'b00, "R8 same addr diff tag");
        do_cmp(64'h5555_0000_0000_1000, 64'hAAAA_0000_0009_0000, 2'b00, "R8 all differ");
    endtask

    task automatic test_cmp_stall();
        @(negedge clk);
        cmp_rsp_ready = 1'b0; cmp_valid = 1'b1;
        cmp_ptr_a = 64'h0101_0000_0000_0001; cmp_ptr_b = 64'h0101_0000_0000_0002;
        @(negedge clk);
        cmp_ptr_b = 64'h0202_0000_0000_0002;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk(cmp_rsp_kind == 2'b10 && cmp_ready == 1'b0, "R9 compare held",
                {62'd0, cmp_rsp_kind}, 64'd2);
        end
        cmp_rsp_ready = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(cmp_rsp_kind == 2'b00 && !cmp_rsp_barrier, "R9 R8 next compare after release",
            {62'd0, cmp_rsp_kind}, 64'd0);
    endtask

    task automatic test_concurrent();
        logic [63:0] exp_a;
        logic [47:0] a = 48'h0000_CAFE_0100;
        @(negedge clk);
        alloc_valid = 1'b1; alloc_addr = a;
        exp_a = {m_lfsr ^ fold(a), a};
        drv_valid = 1'b1; drv_fwd = 1'b1; drv_parent = 64'h9999_0000_0000_0100; drv_addr = 48'h0000_0000_0200;
        cmp_valid = 1'b1; cmp_ptr_a = 64'h9999_0000_0000_0100; cmp_ptr_b = 64'h9999_0000_0000_0200;
        @(negedge clk);
        alloc_valid = 1'b0; drv_valid = 1'b0; cmp_valid = 1'b0;
        m_lfsr = step(m_lfsr);
        chk(alloc_rsp_ptr == exp_a, "R10 alloc alongside others", alloc_rsp_ptr, exp_a);
        chk(drv_rsp_ptr == 64'h9999_0000_0000_0200, "R10 derive alongside others",
            drv_rsp_ptr, 64'h9999_0000_0000_0200);
        chk(cmp_rsp_kind == 2'b10 && cmp_rsp_barrier, "R10 compare alongside others",
            {62'd0, cmp_rsp_kind}, 64'd2);
    endtask

    task automatic test_reseed();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_lfsr = 16'hACE1;
        do_alloc(48'h0000_0000_1000, "R1 reseed after second reset");
    endtask

    initial begin
        test_reset();
        test_alloc_sequence();
        test_alloc_stall();
        test_derive();
        test_compare();
        test_cmp_stall();
        test_concurrent();
        test_reseed();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule